// File: doc/BRIEF.md
# Indirect Flash Read Engine

This block moves a bulk read from a serial flash into a local word FIFO without the host having to run each flash command itself. The host writes a flash start address and a length in bytes, then writes the start bit. The engine turns the length into a count of 32-bit words and asks a word source, which stands in for the flash pin protocol, for one word at a time with a request/ready handshake. Each word that comes back is pushed into the FIFO.

The host polls the level register, or waits for the interrupt line, and pops words from the data port. The engine raises sticky status bits when the FIFO reaches a byte watermark, when it becomes full, when a transfer completes, when a start is rejected and when the data port underflows. Each status bit is cleared by writing one to it, and a mask selects which bits drive the interrupt output. A cancel stops the transfer at once and empties the FIFO.

Register word addresses on `reg_addr_i`: 0 control, 1 flash start address, 2 byte length, 3 watermark in bytes, 4 FIFO level, 5 interrupt status, 6 interrupt mask, 7 data port.

Top module: `indirect_rd_engine`

## Requirements
- R1: After reset the control, level and status registers read 0 and `irq_o` is low. The watermark register reads half the FIFO byte capacity, which is FIFO_DEPTH*4/2.
- R2: Writing control bit 0 while idle starts a transfer of ceil(length/4) words. Requests go out in order at addresses start, start+4, start+8 and so on, with at most one request outstanding. A request that has not been accepted keeps its valid and its address stable.
- R3: Returned words are read from the data port in arrival order. Bits 15:0 of the level register give the number of words held.
- R4: No request is issued while the FIFO holds FIFO_DEPTH words, and the level never exceeds FIFO_DEPTH.
- R5: When every word has arrived and the host has emptied the FIFO, control bit 5 (done) sets and status bit 2 (complete) sets. A length of 0 completes at once. Control bit 4 reads 1 while a transfer is active.
- R6: Writing 1 to control bit 5 clears done.
- R7: Writing control bit 0 while a transfer is active sets status bit 3 (rejected) and leaves the running transfer unchanged.
- R8: Writing control bit 1 (cancel) stops further requests, empties the FIFO and returns the engine to idle without setting done. A response still in flight is discarded.
- R9: Reading the data port while the FIFO is empty returns 0 and sets status bit 1 (underflow).
- R10: Status bit 6 sets when the FIFO level in bytes (words*4) rises to or above the watermark register. A watermark of 0 disables this bit.
- R11: Status bit 12 sets when the FIFO becomes full.
- R12: Writing 1 to a status bit clears that bit only. `irq_o` is high exactly when some status bit is set and its bit in the mask register is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the FIFO at the data port) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the cycle of the read strobe |
| req_valid_o | output | 1 | Word request to the flash source |
| req_ready_i | input | 1 | Flash source accepts the request |
| req_addr_o | output | ADDR_W | Byte address of the requested word |
| rsp_valid_i | input | 1 | Returned word is valid |
| rsp_data_i | input | 32 | Returned word |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions assume that the host never strobes a read and a write in the same cycle. They also assume that the flash source returns exactly one response for each accepted request and never returns one while nothing is outstanding. The bench flash model enforces this by tracking its single pending request and answering it after a programmable latency, optionally with ready toggling every cycle. The host tasks issue one register access at a time. In normal transfers they pop the data port only after the level register has shown a nonzero value, so underflow occurs only in the test that provokes it deliberately.

// File: rtl/ird_pkg.sv
package ird_pkg;
  localparam int REG_W    = 32;
  localparam int REG_AW   = 3;
  localparam int WORD_B   = 4;
  localparam int WORD_SH  = 2;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_ADDR  = 3'd1;
  localparam logic [REG_AW-1:0] A_LEN   = 3'd2;
  localparam logic [REG_AW-1:0] A_WMARK = 3'd3;
  localparam logic [REG_AW-1:0] A_LEVEL = 3'd4;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd5;
  localparam logic [REG_AW-1:0] A_MASK  = 3'd6;
  localparam logic [REG_AW-1:0] A_DATA  = 3'd7;

  localparam int CTL_START  = 0;
  localparam int CTL_CANCEL = 1;
  localparam int CTL_BUSY   = 4;
  localparam int CTL_DONE   = 5;

  localparam int IRQ_N     = 13;
  localparam int IRQ_UNDER = 1;
  localparam int IRQ_CMPL  = 2;
  localparam int IRQ_REJ   = 3;
  localparam int IRQ_WMARK = 6;
  localparam int IRQ_FULL  = 12;
  localparam logic [IRQ_N-1:0] IRQ_IMPL = 13'h104E;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} seq_state_e;
endpackage

// File: rtl/ird_fifo.sv
module ird_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [W-1:0]     rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign level_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == LVL_W'(DEPTH));
endmodule

// File: rtl/ird_seq.sv
module ird_seq
  import ird_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cancel_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic              fifo_empty_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              push_o,
  output logic              flush_o,
  output logic              busy_o,
  output logic              done_set_o,
  output logic              reject_o
);
  localparam int WC_W = CNT_W + 1;

  seq_state_e        state_q;
  logic [WC_W-1:0]   total_q, issued_q, rcvd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              outst_q;
  logic              run, rsp_take;
  logic [WC_W-1:0]   words;

  assign run      = (state_q == ST_RUN);
  assign rsp_take = rsp_valid_i && outst_q;
  assign words    = (WC_W'(byte_cnt_i) + WC_W'(WORD_B - 1)) >> WORD_SH;

  assign req_valid_o = run && !cancel_i && !outst_q && (issued_q != total_q)
                       && (fifo_level_i < LVL_W'(DEPTH));
  assign req_addr_o  = addr_q;
  assign push_o      = run && rsp_take && !cancel_i;
  assign flush_o     = cancel_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign reject_o    = start_i && busy_o;
  assign done_set_o  = run && !cancel_i && !outst_q && (rcvd_q == total_q) && fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      total_q  <= '0;
      issued_q <= '0;
      rcvd_q   <= '0;
      addr_q   <= '0;
      outst_q  <= 1'b0;
    end else begin
      if (req_valid_o && req_ready_i) begin
        outst_q  <= 1'b1;
        issued_q <= issued_q + 1'b1;
        addr_q   <= addr_q + ADDR_W'(WORD_B);
      end else if (rsp_take) begin
        outst_q <= 1'b0;
      end
      if (push_o) rcvd_q <= rcvd_q + 1'b1;
      case (state_q)
        ST_IDLE: if (start_i && !cancel_i) begin
          state_q  <= ST_RUN;
          total_q  <= words;
          issued_q <= '0;
          rcvd_q   <= '0;
          addr_q   <= base_addr_i;
        end
        ST_RUN: begin
          if (cancel_i)        state_q <= (outst_q && !rsp_valid_i) ? ST_DRAIN : ST_IDLE;
          else if (done_set_o) state_q <= ST_IDLE;
        end
        ST_DRAIN: if (rsp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ird_irq.sv
module ird_irq #(
  parameter int               N    = 13,
  parameter logic [N-1:0]     IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      logic st_q, mk_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          st_q <= 1'b0;
          mk_q <= 1'b0;
        end else begin
          // set wins over a same-cycle clear
          if (set_i[b])                     st_q <= 1'b1;
          else if (clr_we_i && wdata_i[b])  st_q <= 1'b0;
          if (mask_we_i)                    mk_q <= wdata_i[b];
        end
      end
      assign stat_o[b] = st_q;
      assign mask_o[b] = mk_q;
    end else begin : g_none
      assign stat_o[b] = 1'b0;
      assign mask_o[b] = 1'b0;
    end
  end

  assign irq_o = |(stat_o & mask_o);
endmodule

// File: rtl/indirect_rd_engine.sv
module indirect_rd_engine
  import ird_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [REG_W-1:0]  rsp_data_i,
  output logic              irq_o
);
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1);
  localparam int LB_W      = LVL_W + WORD_SH;
  localparam int WMARK_RST = FIFO_DEPTH * WORD_B / 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  len_q;
  logic [REG_W-1:0]  wmark_q;
  logic              done_q, wm_q, full_q;

  logic wr_ctrl, start, cancel, done_clr, data_rd, pop, underflow;
  logic push, flush, busy, done_set, reject, fifo_empty, fifo_full, wm_hit;
  logic [LVL_W-1:0] fifo_level;
  logic [REG_W-1:0] fifo_rdata;
  logic [LB_W-1:0]  level_bytes;
  logic [IRQ_N-1:0] irq_set, irq_stat, irq_mask;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign start     = wr_ctrl && reg_wdata_i[CTL_START];
  assign cancel    = wr_ctrl && reg_wdata_i[CTL_CANCEL];
  assign done_clr  = wr_ctrl && reg_wdata_i[CTL_DONE];
  assign data_rd   = reg_re_i && (reg_addr_i == A_DATA);
  assign pop       = data_rd && !fifo_empty && !flush;
  assign underflow = data_rd && fifo_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      len_q   <= '0;
      wmark_q <= REG_W'(WMARK_RST);
      done_q  <= 1'b0;
      wm_q    <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == A_ADDR)  base_q  <= reg_wdata_i[ADDR_W-1:0];
      if (reg_we_i && reg_addr_i == A_LEN)   len_q   <= reg_wdata_i[CNT_W-1:0];
      if (reg_we_i && reg_addr_i == A_WMARK) wmark_q <= reg_wdata_i;
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      wm_q   <= wm_hit;
      full_q <= fifo_full;
    end
  end

  ird_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cancel_i    (cancel),
    .base_addr_i (base_q),
    .byte_cnt_i  (len_q),
    .fifo_level_i(fifo_level),
    .fifo_empty_i(fifo_empty),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .push_o      (push),
    .flush_o     (flush),
    .busy_o      (busy),
    .done_set_o  (done_set),
    .reject_o    (reject)
  );

  ird_fifo #(
    .W(REG_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(rsp_data_i),
    .pop_i  (pop),
    .flush_i(flush),
    .rdata_o(fifo_rdata),
    .level_o(fifo_level),
    .empty_o(fifo_empty),
    .full_o (fifo_full)
  );

  assign level_bytes = {fifo_level, {WORD_SH{1'b0}}};
  assign wm_hit      = (wmark_q != '0) && (REG_W'(level_bytes) >= wmark_q);

  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_UNDER] = underflow;
    irq_set[IRQ_CMPL]  = done_set;
    irq_set[IRQ_REJ]   = reject;
    irq_set[IRQ_WMARK] = wm_hit && !wm_q;
    irq_set[IRQ_FULL]  = fifo_full && !full_q;
  end

  ird_irq #(.N(IRQ_N), .IMPL(IRQ_IMPL)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (irq_set),
    .clr_we_i (reg_we_i && reg_addr_i == A_STAT),
    .mask_we_i(reg_we_i && reg_addr_i == A_MASK),
    .wdata_i  (reg_wdata_i[IRQ_N-1:0]),
    .stat_o   (irq_stat),
    .mask_o   (irq_mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[CTL_BUSY] = busy;
        reg_rdata_o[CTL_DONE] = done_q;
      end
      A_ADDR:  reg_rdata_o = REG_W'(base_q);
      A_LEN:   reg_rdata_o = REG_W'(len_q);
      A_WMARK: reg_rdata_o = wmark_q;
      A_LEVEL: reg_rdata_o = REG_W'(fifo_level);
      A_STAT:  reg_rdata_o = REG_W'(irq_stat);
      A_MASK:  reg_rdata_o = REG_W'(irq_mask);
      A_DATA:  reg_rdata_o = fifo_empty ? '0 : fifo_rdata;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/indirect_rd_engine_chk.sv
module indirect_rd_engine_chk
  import ird_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              busy,
  input logic              done_q,
  input logic [IRQ_N-1:0]  irq_stat
);
  logic cancel_wr, start_wr;
  assign cancel_wr = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[CTL_CANCEL];
  assign start_wr  = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[CTL_START];

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i && !cancel_wr |=> req_valid_o && $stable(req_addr_o));

  p_level_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= LVL_W'(DEPTH));

  p_no_req_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> fifo_level < LVL_W'(DEPTH));

  p_done_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> fifo_level == '0);

  p_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr && busy |=> irq_stat[IRQ_REJ]);

  p_cancel_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_wr |=> fifo_level == '0 && !req_valid_o);

  p_idle_noreq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !req_valid_o);

  p_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i && reg_addr_i == A_DATA && fifo_level == '0 |=> irq_stat[IRQ_UNDER]);
endmodule

bind indirect_rd_engine indirect_rd_engine_chk #(
  .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_re_i   (reg_re_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_addr_o (req_addr_o),
  .fifo_level (fifo_level),
  .busy       (busy),
  .done_q     (done_q),
  .irq_stat   (irq_stat)
);

// File: tb/indirect_rd_engine_tb.sv
module indirect_rd_engine_tb;
  import ird_pkg::*;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_o, req_ready_i, rsp_valid_i, irq_o;
  logic [31:0] req_addr_o, rsp_data_i;

  int tests = 0, fails = 0, req_cnt = 0, lat = 1;
  bit bp_mode = 1'b0, finished = 1'b0, tgl = 1'b0;

  always #10 clk = ~clk;

  indirect_rd_engine #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h0101};
  endfunction

  // flash word source: one pending request, fixed latency
  initial begin
    int cd;
    logic [31:0] pend;
    cd = 0; pend = '0;
    req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_data_i = '0;
    forever begin
      @(negedge clk); #2;
      rsp_valid_i = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin rsp_valid_i = 1'b1; rsp_data_i = pat(pend); end
      end
      tgl = ~tgl;
      req_ready_i = bp_mode ? tgl : 1'b1;
      if (req_valid_o && req_ready_i && cd == 0) begin
        pend = req_addr_o; req_cnt++; cd = lat;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_re_i = 1'b0;
  endtask

  task automatic drain(input logic [31:0] base, input int nw);
    logic [31:0] v;
    int got, guard;
    got = 0; guard = 0;
    while (got < nw && guard < 4000) begin
      rd(A_LEVEL, v);
      if (v[15:0] != 16'd0) begin
        rd(A_DATA, v);
        chk("R3 data order", v, pat(base + 32'(4 * got)));
        got++;
      end
      guard++;
    end
    if (got < nw) chk("R3 words drained", 32'(got), 32'(nw));
  endtask

  task automatic run_xfer(input logic [31:0] base, input int cnt, input int l, input bit bp);
    logic [31:0] v;
    int nw, r0;
    lat = l; bp_mode = bp;
    wr(A_ADDR, base);
    wr(A_LEN, 32'(cnt));
    r0 = req_cnt;
    wr(A_CTRL, 32'h1);
    nw = (cnt + 3) / 4;
    drain(base, nw);
    repeat (6) @(negedge clk);
    rd(A_CTRL, v);   chk("R5 done and idle", 32'(v[5:4]), 32'h2);
    rd(A_STAT, v);   chk("R5 complete bit", 32'(v[2]), 32'h1);
    chk("R2 request count", 32'(req_cnt - r0), 32'(nw));
    wr(A_CTRL, 32'h20);
    rd(A_CTRL, v);   chk("R6 done cleared", 32'(v[5]), 32'h0);
    wr(A_STAT, 32'h1FFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
    rd(A_LEVEL, v); chk("R1 level", v, 32'h0);
    rd(A_STAT, v);  chk("R1 status", v, 32'h0);
    rd(A_WMARK, v); chk("R1 watermark default", v, 32'(DEPTH * 4 / 2));
    chk("R1 irq", 32'(irq_o), 32'h0);

    // R2 R3 R5 R6 sweep over lengths and latencies
    for (int l = 1; l <= 3; l++)
      for (int c = 0; c <= 20; c++)
        run_xfer(32'h1000 * l + 32'(c * 64), c, l, l == 3);

    // R4 R10 R11 fill without draining
    lat = 1; bp_mode = 1'b0;
    wr(A_WMARK, 32'd12);
    wr(A_ADDR, 32'h8000); wr(A_LEN, 32'd64);
    r0 = req_cnt;
    wr(A_CTRL, 32'h1);
    repeat (100) @(negedge clk);
    rd(A_LEVEL, v); chk("R4 level saturates", v, 32'(DEPTH));
    chk("R4 requests held at full", 32'(req_cnt - r0), 32'(DEPTH));
    rd(A_STAT, v);
    chk("R11 full bit", 32'(v[12]), 32'h1);
    chk("R10 watermark bit", 32'(v[6]), 32'h1);
    drain(32'h8000, 16);
    repeat (6) @(negedge clk);
    rd(A_CTRL, v); chk("R5 done after fill", 32'(v[5]), 32'h1);
    wr(A_CTRL, 32'h20); wr(A_STAT, 32'h1FFF);

    // R10 watermark 0 disables
    wr(A_WMARK, 32'd0);
    wr(A_ADDR, 32'h9000); wr(A_LEN, 32'd40);
    wr(A_CTRL, 32'h1);
    repeat (100) @(negedge clk);
    rd(A_STAT, v);
    chk("R10 watermark disabled", 32'(v[6]), 32'h0);
    chk("R11 full bit again", 32'(v[12]), 32'h1);
    drain(32'h9000, 10);
    repeat (6) @(negedge clk);
    wr(A_CTRL, 32'h20); wr(A_STAT, 32'h1FFF);
    wr(A_WMARK, 32'd16);

    // R7 start while active is rejected and harmless
    lat = 2;
    wr(A_ADDR, 32'hA000); wr(A_LEN, 32'd48);
    r0 = req_cnt;
    wr(A_CTRL, 32'h1);
    wr(A_ADDR, 32'hB000);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R7 reject bit", 32'(v[3]), 32'h1);
    drain(32'hA000, 12);
    repeat (6) @(negedge clk);
    chk("R7 request count unchanged", 32'(req_cnt - r0), 32'd12);
    rd(A_CTRL, v); chk("R7 done", 32'(v[5]), 32'h1);
    wr(A_CTRL, 32'h20); wr(A_STAT, 32'h1FFF);

    // R8 cancel with a response in flight
    lat = 3;
    wr(A_ADDR, 32'hC000); wr(A_LEN, 32'd64);
    wr(A_CTRL, 32'h1);
    repeat (14) @(negedge clk);
    wr(A_CTRL, 32'h2);
    repeat (10) @(negedge clk);
    r0 = req_cnt;
    repeat (20) @(negedge clk);
    chk("R8 no requests after cancel", 32'(req_cnt - r0), 32'h0);
    rd(A_LEVEL, v); chk("R8 fifo flushed", v, 32'h0);
    rd(A_CTRL, v);  chk("R8 idle without done", 32'(v[5:4]), 32'h0);
    rd(A_STAT, v);  chk("R8 no complete bit", 32'(v[2]), 32'h0);
    run_xfer(32'hD000, 9, 1, 1'b0);
    rd(A_STAT, v);  chk("R8 restart not rejected", 32'(v[3]), 32'h0);

    // R9 underflow
    rd(A_DATA, v); chk("R9 empty read value", v, 32'h0);
    rd(A_STAT, v); chk("R9 underflow bit", 32'(v[1]), 32'h1);

    // R12 mask and write-one-to-clear
    chk("R12 irq masked off", 32'(irq_o), 32'h0);
    wr(A_MASK, 32'h2);
    chk("R12 irq on", 32'(irq_o), 32'h1);
    wr(A_STAT, 32'h4);
    rd(A_STAT, v); chk("R12 other bit clear keeps bit1", v, 32'h2);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk("R12 bit1 cleared", v, 32'h0);
    chk("R12 irq off", 32'(irq_o), 32'h0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule